// File: doc/BRIEF.md
# Remote DMA Transfer Engine

This block lets a host move bytes between a local packet buffer memory and a host-visible data port, one port access at a time. The host writes a 16-bit buffer address and a 16-bit byte count through pairs of byte-wide registers. It then starts a transfer by writing a command code into bits 5:3 of the command register. After that it pulls bytes out of, or pushes bytes into, the data port until the count is used up.

Each accepted data-port access moves one byte. When word mode is selected at the start of a transfer, each access moves two bytes instead. The engine reaches the buffer memory through a byte-wide request/acknowledge handshake. On a read it fetches ahead, so the port already holds valid data when the host strobes it. The current buffer address can be read back at any time. A sticky completion flag reports that a transfer has ended, whether it ran to its count or was aborted.

Top module: `rdma_engine`

## Requirements
- R1: After reset the engine is idle, `port_ready` is low, the current address reads back as 0x0000 and the completion flag (offset 0x07, bit 6) is clear.
- R2: A register write to offset 0x00 decodes bits 5:3 as a command: 1 starts a read transfer, 2 starts a write transfer, 4 aborts. Every other code, including 3, starts nothing.
- R3: Offsets 0x08/0x09 take the low/high start-address byte and offsets 0x0A/0x0B take the low/high byte count. Reading 0x08/0x09 returns the current address, which is loaded from the start address when a transfer begins and advances by one (byte mode) or two (word mode) on each accepted port access.
- R4: In a byte-mode read, each host strobe of `port_rd` while `port_ready` is high returns the buffer byte at the current address on `port_rdata[7:0]`, with `port_rdata[15:8]` at zero.
- R5: When `word_mode` is high at the start command, each access moves two bytes, with the lower-addressed byte on bits 7:0. An odd byte count is rounded up to the next even value.
- R6: In a write transfer, each `port_wr` strobe while `port_ready` is high stores `port_wdata[7:0]`, and in word mode also `port_wdata[15:8]`, at the current address and the one after it.
- R7: A transfer ends exactly on the access that brings the remaining count to zero. At that point the completion flag sets, `port_ready` falls and the engine is idle.
- R8: An abort command during a transfer ends it at once and sets the completion flag. An abort while idle leaves the flag unchanged.
- R9: A read or write command with an effective count of zero moves no data, keeps `port_ready` low and sets the completion flag.
- R10: A data-port strobe while `port_ready` is low is ignored. It touches neither memory nor the current address, and `port_rdata` reads zero.
- R11: Writing a 1 to bit 6 of offset 0x07 clears the completion flag.
- R12: `mem_req` stays high, with a stable address and direction, until `mem_ack`. Each acknowledge moves exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| word_mode | input | 1 | Two bytes per port access, sampled at the start command |
| port_rd | input | 1 | Data-port read strobe |
| port_wr | input | 1 | Data-port write strobe |
| port_wdata | input | 16 | Data-port write data |
| port_rdata | output | 16 | Data-port read data |
| port_ready | output | 1 | Port can accept an access this cycle |
| mem_req | output | 1 | Buffer memory request |
| mem_we | output | 1 | Buffer memory write enable |
| mem_addr | output | 16 | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write byte |
| mem_ack | input | 1 | Buffer memory acknowledge |
| mem_rdata | input | 8 | Buffer memory read byte, valid with `mem_ack` |

## Verification
A wrong remaining count becomes visible at the ports on the final access. The completion flag then rises one access early or late, and `port_ready` stays high or drops too soon. A wrong current address shows up in the same cycle, both in the address readback and in the next memory address.

A prefetch that fills the wrong half of the holding register shows as swapped bytes on `port_rdata` at the next host strobe. A write pointer error shows as bytes landing in the wrong buffer locations, which the bench checks once the transfer has finished.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_READY,
      S_WAITW,
      S_STORE
   } seq_state_e;

   localparam logic [2:0] CMD_READ  = 3'd1;
   localparam logic [2:0] CMD_WRITE = 3'd2;
   localparam logic [2:0] CMD_ABORT = 3'd4;

   localparam logic [3:0] OFS_CMD    = 4'h0;
   localparam logic [3:0] OFS_FLAGS  = 4'h7;
   localparam logic [3:0] OFS_ADR_LO = 4'h8;
   localparam logic [3:0] OFS_ADR_HI = 4'h9;
   localparam logic [3:0] OFS_CNT_LO = 4'hA;
   localparam logic [3:0] OFS_CNT_HI = 4'hB;

   localparam int DONE_BIT = 6;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
   import rdma_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic              done_set,
   output logic              done_flag,
   output logic [ADDR_W-1:0] start_addr,
   output logic [CNT_W-1:0]  byte_cnt,
   output logic              go_read,
   output logic              go_write,
   output logic              go_abort
);
   logic [15:0] start_q, cnt_q, cur16;
   logic        flag_q;
   logic [2:0]  cmd_field;

   assign cmd_field  = reg_wdata[5:3];
   assign go_read    = reg_wr && (reg_addr == OFS_CMD) && (cmd_field == CMD_READ);
   assign go_write   = reg_wr && (reg_addr == OFS_CMD) && (cmd_field == CMD_WRITE);
   assign go_abort   = reg_wr && (reg_addr == OFS_CMD) && (cmd_field == CMD_ABORT);
   assign start_addr = start_q[ADDR_W-1:0];
   assign byte_cnt   = cnt_q[CNT_W-1:0];
   assign done_flag  = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         cnt_q   <= '0;
         flag_q  <= 1'b0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               OFS_ADR_LO: start_q[7:0]  <= reg_wdata;
               OFS_ADR_HI: start_q[15:8] <= reg_wdata;
               OFS_CNT_LO: cnt_q[7:0]    <= reg_wdata;
               OFS_CNT_HI: cnt_q[15:8]   <= reg_wdata;
               default: ;
            endcase
         end
         if (done_set)
            flag_q <= 1'b1;
         else if (reg_wr && reg_addr == OFS_FLAGS && reg_wdata[DONE_BIT])
            flag_q <= 1'b0;
      end
   end

   always_comb begin
      cur16 = '0;
      cur16[ADDR_W-1:0] = cur_addr;
      reg_rdata = '0;
      case (reg_addr)
         OFS_FLAGS:  reg_rdata[DONE_BIT] = flag_q;
         OFS_ADR_LO: reg_rdata = cur16[7:0];
         OFS_ADR_HI: reg_rdata = cur16[15:8];
         default: ;
      endcase
   end
endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
   import rdma_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 16,
   parameter bit WORD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_read,
   input  logic              go_write,
   input  logic              go_abort,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic              word_mode,
   input  logic              port_rd,
   input  logic              port_wr,
   input  logic [15:0]       port_wdata,
   output logic [15:0]       port_rdata,
   output logic              port_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic [7:0]        mem_rdata,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              xfer_word,
   output logic              done_set
);
   localparam int REM_W = CNT_W + 1;

   seq_state_e        state_q;
   logic [ADDR_W-1:0] cur_q, base_q;
   logic [REM_W-1:0]  rem_q, cnt_eff, step;
   logic              idx_q, wmode_q, wm_in, last_byte;
   logic [7:0]        hold0_q, hold1_q;

   if (WORD_EN) begin : g_word
      assign wm_in = word_mode;
   end else begin : g_byte_only
      logic unused_wm;
      assign unused_wm = word_mode;
      assign wm_in     = 1'b0;
   end

   assign cnt_eff   = {1'b0, byte_cnt} + REM_W'(wm_in & byte_cnt[0]);
   assign step      = wmode_q ? REM_W'(2) : REM_W'(1);
   assign last_byte = (idx_q == wmode_q);
   assign cur_addr  = cur_q;
   assign xfer_word = wmode_q;

   always_comb begin
      mem_req    = (state_q == S_FETCH) || (state_q == S_STORE);
      mem_we     = (state_q == S_STORE);
      mem_addr   = ((state_q == S_STORE) ? base_q : cur_q) + ADDR_W'(idx_q);
      mem_wdata  = idx_q ? hold1_q : hold0_q;
      port_ready = (state_q == S_READY) || (state_q == S_WAITW);
      port_rdata = '0;
      if (state_q == S_READY)
         port_rdata = {(wmode_q ? hold1_q : 8'h00), hold0_q};
      done_set = 1'b0;
      if (go_abort)
         done_set = (state_q != S_IDLE);
      else if (state_q == S_IDLE)
         done_set = (go_read || go_write) && (cnt_eff == '0);
      else if (state_q == S_READY)
         done_set = port_rd && (rem_q == step);
      else if (state_q == S_STORE)
         done_set = mem_ack && last_byte && (rem_q == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cur_q   <= '0;
         base_q  <= '0;
         rem_q   <= '0;
         idx_q   <= 1'b0;
         wmode_q <= 1'b0;
         hold0_q <= '0;
         hold1_q <= '0;
      end else if (go_abort) begin
         state_q <= S_IDLE;
         idx_q   <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if ((go_read || go_write) && cnt_eff != '0) begin
                  cur_q   <= start_addr;
                  rem_q   <= cnt_eff;
                  wmode_q <= wm_in;
                  idx_q   <= 1'b0;
                  state_q <= go_read ? S_FETCH : S_WAITW;
               end
            end
            S_FETCH: begin
               if (mem_ack) begin
                  if (idx_q) hold1_q <= mem_rdata;
                  else       hold0_q <= mem_rdata;
                  idx_q <= ~last_byte;
                  if (last_byte) state_q <= S_READY;
               end
            end
            S_READY: begin
               if (port_rd) begin
                  cur_q   <= cur_q + ADDR_W'(step);
                  rem_q   <= rem_q - step;
                  state_q <= (rem_q == step) ? S_IDLE : S_FETCH;
               end
            end
            S_WAITW: begin
               if (port_wr) begin
                  hold0_q <= port_wdata[7:0];
                  hold1_q <= port_wdata[15:8];
                  base_q  <= cur_q;
                  cur_q   <= cur_q + ADDR_W'(step);
                  rem_q   <= rem_q - step;
                  idx_q   <= 1'b0;
                  state_q <= S_STORE;
               end
            end
            S_STORE: begin
               if (mem_ack) begin
                  idx_q <= ~last_byte;
                  if (last_byte) state_q <= (rem_q == '0) ? S_IDLE : S_WAITW;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine #(
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 16,
   parameter bit WORD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              word_mode,
   input  logic              port_rd,
   input  logic              port_wr,
   input  logic [15:0]       port_wdata,
   output logic [15:0]       port_rdata,
   output logic              port_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic [7:0]        mem_rdata
);
   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
      $error("rdma_engine: ADDR_W must lie in 9..16");
   end
   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt_w
      $error("rdma_engine: CNT_W must lie in 9..16");
   end

   logic [ADDR_W-1:0] start_addr, cur_addr;
   logic [CNT_W-1:0]  byte_cnt;
   logic              go_read, go_write, go_abort, done_set, done_flag, xfer_word;

   rdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .cur_addr   (cur_addr),
      .done_set   (done_set),
      .done_flag  (done_flag),
      .start_addr (start_addr),
      .byte_cnt   (byte_cnt),
      .go_read    (go_read),
      .go_write   (go_write),
      .go_abort   (go_abort)
   );

   rdma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_EN(WORD_EN)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_read    (go_read),
      .go_write   (go_write),
      .go_abort   (go_abort),
      .start_addr (start_addr),
      .byte_cnt   (byte_cnt),
      .word_mode  (word_mode),
      .port_rd    (port_rd),
      .port_wr    (port_wr),
      .port_wdata (port_wdata),
      .port_rdata (port_rdata),
      .port_ready (port_ready),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .cur_addr   (cur_addr),
      .xfer_word  (xfer_word),
      .done_set   (done_set)
   );
endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [3:0]        reg_addr,
   input logic [7:0]        reg_wdata,
   input logic              port_rd,
   input logic              port_wr,
   input logic              port_ready,
   input logic [15:0]       port_rdata,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              xfer_word,
   input logic              done_flag
);
   logic abort_wr;
   assign abort_wr = reg_wr && reg_addr == 4'h0 && reg_wdata[5:3] == 3'd4;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !abort_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))) // R12
      else $error("AST_REQ_HELD");

   AST_PORT_OR_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, port_ready})) // R4
      else $error("AST_PORT_OR_MEM");

   AST_IGNORED_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ((port_rd || port_wr) && !port_ready && !reg_wr) |=> $stable(cur_addr)) // R10
      else $error("AST_IGNORED_STROBE");

   AST_QUIET_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      !port_ready |-> (port_rdata == 16'h0000)) // R10
      else $error("AST_QUIET_PORT");

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (port_ready && (port_rd || port_wr) && !abort_wr)
         |=> (cur_addr == $past(cur_addr) + ($past(xfer_word) ? ADDR_W'(2) : ADDR_W'(1)))) // R3
      else $error("AST_ADDR_STEP");

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> !port_ready) // R7
      else $error("AST_DONE_IDLE");

   AST_ABORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_wr && (port_ready || mem_req)) |=> (done_flag && !port_ready && !mem_req)) // R8
      else $error("AST_ABORT_DONE");
endmodule

bind rdma_engine rdma_engine_chk #(.ADDR_W(ADDR_W)) i_rdma_engine_chk (.*);

// File: tb/test_rdma_engine.sv
module test_rdma_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        word_mode = 1'b0;
   logic        port_rd = 1'b0, port_wr = 1'b0;
   logic [15:0] port_wdata = '0;
   logic [15:0] port_rdata;
   logic        port_ready;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_ack = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic [7:0]  mem [256];

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   rdma_engine i_rdma_engine (.*);

   always_ff @(posedge clk) begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         mem_rdata <= mem[mem_addr[7:0]];
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd_cur(output int v);
      logic [7:0] lo, hi;
      reg_read(4'h8, lo);
      reg_read(4'h9, hi);
      v = {hi, lo};
   endtask

   task automatic rd_flag(output int v);
      logic [7:0] f;
      reg_read(4'h7, f);
      v = f[6];
   endtask

   task automatic clr_flag();
      reg_write(4'h7, 8'h40);
   endtask

   task automatic setup(int a, int n, bit w);
      reg_write(4'h8, a[7:0]);
      reg_write(4'h9, a[15:8]);
      reg_write(4'hA, n[7:0]);
      reg_write(4'hB, n[15:8]);
      word_mode = w;
   endtask

   task automatic port_read(output logic [15:0] d);
      int guard = 0;
      @(negedge clk);
      while (!port_ready && guard < 40) begin @(negedge clk); guard++; end
      d = port_rdata;
      port_rd = 1'b1;
      @(negedge clk);
      port_rd = 1'b0;
   endtask

   task automatic port_write(logic [15:0] d);
      int guard = 0;
      @(negedge clk);
      while (!port_ready && guard < 40) begin @(negedge clk); guard++; end
      port_wr = 1'b1; port_wdata = d;
      @(negedge clk);
      port_wr = 1'b0;
   endtask

   task automatic t_reset();
      int v;
      chk("R1 port_ready", port_ready, 0);
      rd_cur(v);  chk("R1 cur addr", v, 0);
      rd_flag(v); chk("R1 done flag", v, 0);
   endtask

   task automatic t_byte_read();
      logic [15:0] d; int v;
      setup(16'h0010, 3, 0);
      reg_write(4'h0, 8'h08);
      port_read(d); chk("R4 byte0", d, {8'h00, mem[8'h10]});
      rd_cur(v);    chk("R3 cur mid", v, 16'h0011);
      rd_flag(v);   chk("R7 no early done", v, 0);
      port_read(d); chk("R4 byte1", d, {8'h00, mem[8'h11]});
      port_read(d); chk("R4 byte2", d, {8'h00, mem[8'h12]});
      @(negedge clk);
      chk("R7 ready low", port_ready, 0);
      rd_flag(v);   chk("R7 done set", v, 1);
      rd_cur(v);    chk("R3 cur end", v, 16'h0013);
      clr_flag();
      rd_flag(v);   chk("R11 flag cleared", v, 0);
   endtask

   task automatic t_word_read();
      logic [15:0] d; int v;
      setup(16'h0020, 5, 1);
      reg_write(4'h0, 8'h08);
      for (int k = 0; k < 3; k++) begin
         port_read(d);
         chk("R5 word read", d, {mem[8'h21 + 2*k], mem[8'h20 + 2*k]});
      end
      @(negedge clk);
      chk("R5 odd count rounded, ready low", port_ready, 0);
      rd_flag(v); chk("R5 done after rounding", v, 1);
      rd_cur(v);  chk("R5 cur", v, 16'h0026);
      clr_flag();
   endtask

   task automatic t_abort_and_idle();
      logic [15:0] d; int v; logic [7:0] keep;
      setup(16'h0040, 4, 0);
      reg_write(4'h0, 8'h08);
      port_read(d); chk("R4 pre-abort byte", d, {8'h00, mem[8'h40]});
      reg_write(4'h0, 8'h20);
      @(negedge clk);
      chk("R8 ready low", port_ready, 0);
      chk("R8 no mem req", mem_req, 0);
      rd_flag(v); chk("R8 done on abort", v, 1);
      rd_cur(v);  chk("R8 cur kept", v, 16'h0041);
      clr_flag();
      keep = mem[8'h41];
      port_read(d);       chk("R10 idle rdata", d, 0);
      port_write(16'hFFFF);
      repeat (3) @(negedge clk);
      chk("R10 mem untouched", mem[8'h41], keep);
      rd_cur(v);  chk("R10 cur untouched", v, 16'h0041);
      reg_write(4'h0, 8'h20);
      rd_flag(v); chk("R8 idle abort no flag", v, 0);
   endtask

   task automatic t_byte_write();
      int v; logic [7:0] keep;
      keep = mem[8'h82];
      setup(16'h0080, 2, 0);
      reg_write(4'h0, 8'h10);
      port_write(16'h9911);
      port_write(16'h8822);
      repeat (4) @(negedge clk);
      chk("R6 byte0", mem[8'h80], 8'h11);
      chk("R6 byte1", mem[8'h81], 8'h22);
      chk("R6 upper ignored", mem[8'h82], keep);
      rd_flag(v); chk("R7 write done", v, 1);
      rd_cur(v);  chk("R3 write cur", v, 16'h0082);
      clr_flag();
   endtask

   task automatic t_word_write();
      int v;
      setup(16'h0090, 4, 1);
      reg_write(4'h0, 8'h10);
      port_write(16'hBBAA);
      rd_flag(v); chk("R7 no early done write", v, 0);
      port_write(16'hDDCC);
      repeat (6) @(negedge clk);
      chk("R5 w0 lo", mem[8'h90], 8'hAA);
      chk("R5 w0 hi", mem[8'h91], 8'hBB);
      chk("R5 w1 lo", mem[8'h92], 8'hCC);
      chk("R6 w1 hi", mem[8'h93], 8'hDD);
      rd_flag(v); chk("R7 word write done", v, 1);
      clr_flag();
   endtask

   task automatic t_zero_and_other_cmd();
      int v;
      setup(16'h0000, 0, 0);
      reg_write(4'h0, 8'h08);
      @(negedge clk);
      chk("R9 ready low", port_ready, 0);
      rd_flag(v); chk("R9 flag set", v, 1);
      clr_flag();
      setup(16'h0010, 2, 0);
      reg_write(4'h0, 8'h18);
      repeat (4) @(negedge clk);
      chk("R2 code 3 starts nothing", port_ready, 0);
      chk("R2 code 3 no mem", mem_req, 0);
      rd_flag(v); chk("R2 code 3 no flag", v, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_byte_read();
      t_word_read();
      t_abort_and_idle();
      t_byte_write();
      t_word_write();
      t_zero_and_other_cmd();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule